// File: doc/BRIEF.md
# Clock Lane Burst Sequencer

This block walks the transmit side of a serial clock lane through the line states around one high-speed clock burst. While idle the lane rests in LP-11. When a burst is requested it steps through LP-01 and LP-00, drives HS-0, and then starts the toggling high-speed clock. After an interval of toggling it tells the data lanes that they may leave low power. When the request is dropped and the data lanes report idle, the clock keeps toggling for a trailing interval. It then drives HS-0 and returns to LP-11.

Every interval is a count of reference-clock cycles taken from a configuration input. The count is captured at the cycle that starts a burst, and a count of zero lasts one cycle. The line state leaves the block as a small code, and an analog driver stage turns that code into pin levels. The block contains no drivers, no termination and no clock generation.

Top module: `clklane_burst_seq`

## Requirements
- R1: While reset is applied and after reset, `line_state` is 0 (LP-11) and `data_ok` is 0.
- R2: A high `hs_req` sampled at a clock edge while the lane idles in LP-11 makes `line_state` equal 1 (LP-01) from that edge onward for max(`cfg_lpx`,1) cycles.
- R3: LP-01 is followed by `line_state` 2 (LP-00), which lasts max(`cfg_prep`,1) cycles.
- R4: LP-00 is followed by `line_state` 3 (HS-0), which lasts max(`cfg_zero`,1) cycles before toggling starts.
- R5: Toggling (`line_state` 4) first runs for max(`cfg_pre`,1) cycles with `data_ok` 0. Then `data_ok` goes to 1. `data_ok` is never 1 outside toggling.
- R6: While `data_ok` is 1, the lane keeps toggling with `data_ok` 1 for as long as `hs_req` is 1 or `data_idle` is 0.
- R7: If an edge during `data_ok` samples `hs_req` 0 and `data_idle` 1, then `data_ok` is 0 from that edge on. The lane keeps toggling for max(`cfg_post`,1) cycles.
- R8: After the trailing toggle, `line_state` 3 (HS-0) lasts max(`cfg_trail`,1) cycles. Then LP-11 lasts at least max(`cfg_lpx`,1) cycles, with the LPX value captured for the burst that is ending.
- R9: A request that is present while the lane is exiting is held and not lost. When `hs_req` is already high on the first LP-11 cycle after HS-0, LP-01 begins exactly max(lpx,1)+1 cycles later.
- R10: Interval counts are captured at the edge that starts a burst. Changing the `cfg_*` inputs later in that burst has no effect on its durations.
- R11: A configured count of 0 gives an interval of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | Request for high-speed clocking |
| data_idle | input | 1 | All data lanes are back in low power |
| cfg_lpx | input | CNT_W | Low-power state length, in cycles |
| cfg_prep | input | CNT_W | LP-00 prepare length, in cycles |
| cfg_zero | input | CNT_W | HS-0 length before toggling, in cycles |
| cfg_pre | input | CNT_W | Toggling length before data is allowed, in cycles |
| cfg_post | input | CNT_W | Toggling length after data ends, in cycles |
| cfg_trail | input | CNT_W | HS-0 length after the last clock bit, in cycles |
| line_state | output | 3 | Line code: 0 LP-11, 1 LP-01, 2 LP-00, 3 HS-0, 4 toggling |
| data_ok | output | 1 | Data lanes may begin their transition to high speed |

## Verification
`line_state` and `data_ok` are decoded from a registered state. Each of them therefore changes at the first rising edge that samples a new input, and one cycle after a timer reaches its last count. The bench drives inputs on falling edges and samples outputs on falling edges. Each interval is measured as the number of consecutive falling-edge samples that show the same (line_state, data_ok) pair, and that number must equal the clamped count exactly. The held-request case is checked by counting the LP-11 samples in which the request is already pending. That count must be the exit hold plus the single idle cycle.

// File: rtl/clklane_pkg.sv
package clklane_pkg;

    localparam int NUM_IV   = 6;
    localparam int IV_LPX   = 0;
    localparam int IV_PREP  = 1;
    localparam int IV_ZERO  = 2;
    localparam int IV_PRE   = 3;
    localparam int IV_POST  = 4;
    localparam int IV_TRAIL = 5;

    // encoded line state seen by the driver stage
    typedef enum logic [2:0] {
        LS_STOP  = 3'd0,
        LS_LP01  = 3'd1,
        LS_LP00  = 3'd2,
        LS_HS0   = 3'd3,
        LS_HSCLK = 3'd4
    } line_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_BRIDGE,
        SQ_ZERO,
        SQ_PRE,
        SQ_RUN,
        SQ_POST,
        SQ_TRAIL,
        SQ_EXIT
    } seq_e;

endpackage

// File: rtl/clklane_cfg_latch.sv
module clklane_cfg_latch
    import clklane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture,
    input  logic [NUM_IV-1:0][CNT_W-1:0]  raw,
    output logic [NUM_IV-1:0][CNT_W-1:0]  clamped_raw,
    output logic [NUM_IV-1:0][CNT_W-1:0]  held
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [NUM_IV-1:0][CNT_W-1:0] val;
    } lat_s;

    lat_s lat_d, lat_q;

    // a zero count is promoted to a single cycle
    for (genvar g = 0; g < NUM_IV; g++) begin : g_clamp
        assign clamped_raw[g] = (raw[g] == '0) ? ONE : raw[g];
    end

    always_comb begin
        lat_d = lat_q;
        if (capture) begin
            lat_d.val = clamped_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IV; i++) begin
                lat_q.val[i] <= ONE;
            end
        end else begin
            lat_q <= lat_d;
        end
    end

    assign held = lat_q.val;

endmodule

// File: rtl/clklane_interval_timer.sv
module clklane_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt > ONE) begin
            tmr_d.cnt = tmr_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= ONE;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last = (tmr_q.cnt == ONE);

endmodule

// File: rtl/clklane_line_enc.sv
module clklane_line_enc
    import clklane_pkg::*;
(
    input  seq_e        st,
    output logic [2:0]  line_code,
    output logic        data_ok
);

    line_e ls;

    always_comb begin
        ls      = LS_STOP;
        data_ok = 1'b0;
        case (st)
            SQ_REQ:    ls = LS_LP01;
            SQ_BRIDGE: ls = LS_LP00;
            SQ_ZERO:   ls = LS_HS0;
            SQ_PRE:    ls = LS_HSCLK;
            SQ_RUN: begin
                ls      = LS_HSCLK;
                data_ok = 1'b1;
            end
            SQ_POST:   ls = LS_HSCLK;
            SQ_TRAIL:  ls = LS_HS0;
            default:   ls = LS_STOP;
        endcase
    end

    assign line_code = ls;

endmodule

// File: rtl/clklane_burst_seq.sv
module clklane_burst_seq
    import clklane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_req,
    input  logic             data_idle,
    input  logic [CNT_W-1:0] cfg_lpx,
    input  logic [CNT_W-1:0] cfg_prep,
    input  logic [CNT_W-1:0] cfg_zero,
    input  logic [CNT_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic [CNT_W-1:0] cfg_trail,
    output logic [2:0]       line_state,
    output logic             data_ok
);

    typedef struct packed {
        seq_e st;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    logic [NUM_IV-1:0][CNT_W-1:0] raw_cfg;
    logic [NUM_IV-1:0][CNT_W-1:0] now_cfg;
    logic [NUM_IV-1:0][CNT_W-1:0] lat_cfg;
    logic                         cap;
    logic                         tmr_load;
    logic [CNT_W-1:0]             tmr_val;
    logic                         tmr_last;

    assign raw_cfg[IV_LPX]   = cfg_lpx;
    assign raw_cfg[IV_PREP]  = cfg_prep;
    assign raw_cfg[IV_ZERO]  = cfg_zero;
    assign raw_cfg[IV_PRE]   = cfg_pre;
    assign raw_cfg[IV_POST]  = cfg_post;
    assign raw_cfg[IV_TRAIL] = cfg_trail;

    clklane_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (cap),
        .raw         (raw_cfg),
        .clamped_raw (now_cfg),
        .held        (lat_cfg)
    );

    clklane_interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        fsm_d    = fsm_q;
        cap      = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = lat_cfg[IV_LPX];
        case (fsm_q.st)
            SQ_IDLE: begin
                if (hs_req) begin
                    fsm_d.st = SQ_REQ;
                    cap      = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = now_cfg[IV_LPX];
                end
            end
            SQ_REQ: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_BRIDGE;
                    tmr_load = 1'b1;
                    tmr_val  = lat_cfg[IV_PREP];
                end
            end
            SQ_BRIDGE: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_ZERO;
                    tmr_load = 1'b1;
                    tmr_val  = lat_cfg[IV_ZERO];
                end
            end
            SQ_ZERO: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = lat_cfg[IV_PRE];
                end
            end
            SQ_PRE: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_RUN;
                end
            end
            SQ_RUN: begin
                if (!hs_req && data_idle) begin
                    fsm_d.st = SQ_POST;
                    tmr_load = 1'b1;
                    tmr_val  = lat_cfg[IV_POST];
                end
            end
            SQ_POST: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = lat_cfg[IV_TRAIL];
                end
            end
            SQ_TRAIL: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = lat_cfg[IV_LPX];
                end
            end
            SQ_EXIT: begin
                if (tmr_last) begin
                    fsm_d.st = SQ_IDLE;
                end
            end
            default: fsm_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st <= SQ_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    clklane_line_enc u_enc (
        .st        (fsm_q.st),
        .line_code (line_state),
        .data_ok   (data_ok)
    );

endmodule

// File: rtl/clklane_burst_seq_chk.sv
module clklane_burst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_req,
    input logic       data_idle,
    input logic [2:0] line_state,
    input logic       data_ok
);

    // R5
    data_only_toggling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ok |-> line_state == 3'd4);

    // R5
    data_after_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ok) |-> $past(line_state) == 3'd4);

    // R7
    data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ok) |-> ($past(!hs_req) && $past(data_idle)));

    // R2
    lp01_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd1 && $past(line_state) != 3'd1) |-> $past(line_state) == 3'd0);

    // R3
    lp00_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd2 && $past(line_state) != 3'd2) |-> $past(line_state) == 3'd1);

    // R4
    hs0_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd3 && $past(line_state) != 3'd3)
        |-> ($past(line_state) == 3'd2 || $past(line_state) == 3'd4));

    // R8
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 3'd0 && $past(line_state) != 3'd0) |-> $past(line_state) == 3'd3);

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_state <= 3'd4);

endmodule

bind clklane_burst_seq clklane_burst_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_req     (hs_req),
    .data_idle  (data_idle),
    .line_state (line_state),
    .data_ok    (data_ok)
);

// File: tb/clklane_burst_seq_bench.sv
module clklane_burst_seq_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hs_req = 1'b0;
    logic         data_idle = 1'b0;
    logic [W-1:0] cfg_lpx = 8'd1, cfg_prep = 8'd1, cfg_zero = 8'd1;
    logic [W-1:0] cfg_pre = 8'd1, cfg_post = 8'd1, cfg_trail = 8'd1;
    logic [2:0]   line_state;
    logic         data_ok;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    clklane_burst_seq #(.CNT_W(W)) u_clklane_burst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_req     (hs_req),
        .data_idle  (data_idle),
        .cfg_lpx    (cfg_lpx),
        .cfg_prep   (cfg_prep),
        .cfg_zero   (cfg_zero),
        .cfg_pre    (cfg_pre),
        .cfg_post   (cfg_post),
        .cfg_trail  (cfg_trail),
        .line_state (line_state),
        .data_ok    (data_ok)
    );

    // per vector: lpx, prep, zero, pre, post, trail
    localparam logic [7:0] VEC [4][6] = '{
        '{8'd3, 8'd2, 8'd4, 8'd5, 8'd6, 8'd2},
        '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
        '{8'd5, 8'd4, 8'd2, 8'd8, 8'd3, 8'd7}
    };

    function automatic int span_of(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // counts consecutive falling-edge samples showing the given pair
    task automatic span(input logic [2:0] ls, input logic ok, output int n);
        n = 0;
        while (line_state == ls && data_ok == ok && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input logic [7:0] a, b, c, d, e, f);
        cfg_lpx = a; cfg_prep = b; cfg_zero = c;
        cfg_pre = d; cfg_post = e; cfg_trail = f;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 reset line", int'(line_state), 0);
        chk("R1 reset data_ok", int'(data_ok), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset line", int'(line_state), 0);
        chk("R1 after reset data_ok", int'(data_ok), 0);

        for (int v = 0; v < 4; v++) begin
            set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            data_idle = 1'b0;
            hs_req = 1'b1;
            @(negedge clk);
            // R10: scramble the configuration once the burst is under way
            set_cfg(8'd9, 8'd9, 8'd9, 8'd9, 8'd9, 8'd9);
            span(3'd1, 1'b0, n); chk("R2 LP-01 length", n, span_of(VEC[v][0]));
            span(3'd2, 1'b0, n); chk("R3 LP-00 length", n, span_of(VEC[v][1]));
            span(3'd3, 1'b0, n); chk("R4 HS-0 length", n, span_of(VEC[v][2]));
            span(3'd4, 1'b0, n); chk("R5 pre toggle length", n, span_of(VEC[v][3]));
            chk("R5 data_ok raised", int'(data_ok), 1);
            repeat (3) @(negedge clk);
            chk("R6 still running with request", int'(data_ok), 1);
            hs_req = 1'b0;
            repeat (2) @(negedge clk);
            // R6: request gone but data still busy
            chk("R6 still running, data busy", int'(data_ok), 1);
            data_idle = 1'b1;
            @(negedge clk);
            chk("R7 data_ok dropped", int'(data_ok), 0);
            span(3'd4, 1'b0, n); chk("R7 post toggle length", n, span_of(VEC[v][4]));
            span(3'd3, 1'b0, n); chk("R8 trail length", n, span_of(VEC[v][5]));
            span(3'd0, 1'b0, n); chk("R8 rest in LP-11", n, 1000);
        end
        // R11 is covered by vector 1 (all counts zero)

        // R9 with R10: request pending on the first exit cycle
        set_cfg(8'd4, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1);
        data_idle = 1'b0;
        hs_req = 1'b1;
        @(negedge clk);
        span(3'd1, 1'b0, n); chk("R2 LP-01 length lpx4", n, 4);
        span(3'd2, 1'b0, n);
        span(3'd3, 1'b0, n);
        span(3'd4, 1'b0, n);
        hs_req = 1'b0;
        data_idle = 1'b1;
        @(negedge clk);
        span(3'd4, 1'b0, n); chk("R7 post length one", n, 1);
        span(3'd3, 1'b0, n); chk("R8 trail length one", n, 1);
        hs_req = 1'b1;
        cfg_lpx = 8'd2;
        span(3'd0, 1'b0, n); chk("R9 held request LP-11 length", n, 5);
        span(3'd1, 1'b0, n); chk("R10 new burst uses new lpx", n, 2);

        // R1: reset in the middle of a burst
        rst_n = 1'b0;
        #1;
        chk("R1 async reset line", int'(line_state), 0);
        chk("R1 async reset data_ok", int'(data_ok), 0);
        hs_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'(line_state), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule